// File: doc/BRIEF.md
# Pipelined Burst SRAM Front-End

This block is the synchronous control front-end of a 36-bit pipelined burst SRAM. It has four 9-bit byte lanes and a small internal array. The data bus is split into a write-data input, a read-data output and a drive-enable output, and the pad ring combines them into one tristate bus. Each rising edge decodes the control pins into one of four cycle types: begin a burst, continue a burst, suspend a burst, or deselect. Two address strobes are used. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write, and it checks two extra chip selects.

A 2-bit burst counter works on the two lowest address bits. It steps through four addresses in either linear or interleaved order. Read data appears one clock after the command edge. The drivers are released for writes and for deselects, with one pipeline stage or two depending on the deselect-mode pin. An asynchronous output enable can only mask drivers that are already on. A sleep input stops the block and keeps the memory contents. After sleep ends, a recovery window blocks writes for a set number of cycles.

Top module: `sram_burst_front`

## Requirements
- R1: When `burst_interleave` is low, each continue cycle after a burst start at low bits b uses low bits (b + n) mod 4 for the n-th step, so the fifth address is b again. Address bits above [1:0] stay as they were captured at the start.
- R2: When `burst_interleave` is high, the n-th step of a burst uses low bits b XOR (n mod 4).
- R3: A cycle with `sel_n` low and `proc_strobe_n` low starts a read at `addr`, whatever the write controls are. That cycle writes nothing.
- R4: A cycle with `ctrl_strobe_n` low and `proc_strobe_n` high starts a burst at `addr`. It is a read or a write according to R7, and the write data is taken from `wr_data` on the same edge. If `sel_n` is high while `ctrl_strobe_n` is low, the cycle is a deselect: nothing is written and the drivers are released.
- R5: `sel2` (active high) and `sel3_n` (active low) are checked only in controller-strobe cycles. If either is inactive there, the cycle is a deselect. They do not affect processor-strobe cycles.
- R6: With both strobes high, `advance_n` low continues the burst at the next counter address, and `advance_n` high repeats the current address. Either kind of cycle can read or write.
- R7: With `all_wr_n` low, all four lanes are written. Otherwise, with `lane_wr_n` low, lane i (bits [9i+8:9i]) is written when `lane_sel_n[i]` is low. With no lane selected, the cycle is a read.
- R8: Read data is on `rd_data` and `rd_drive` is high after the edge that follows the read command's edge. `rd_drive` drops on the edge that registers a write.
- R9: When `single_deselect` is high, `rd_drive` drops on the edge that registers a deselect. When it is low, `rd_drive` stays on for one more cycle with the preceding read's data and drops on the next edge.
- R10: `out_en_n` high forces `rd_drive` low at once, without waiting for a clock. `out_en_n` low cannot raise `rd_drive` unless a read result is being driven.
- R11: If `sleep_req` is high at edge k, commands at edges k and k+1 still execute. From then on `rd_drive` is low, commands are ignored and the array contents are kept.
- R12: If `sleep_req` is low at edge m, commands at edges m and m+1 are still ignored. Writes at edges m+2 through m+1+REC_CYC are ignored, while reads and deselects there execute. A write at edge m+2+REC_CYC or later executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | External word address |
| proc_strobe_n | input | 1 | Processor-side address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller-side address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| sel_n | input | 1 | Primary chip select, active low |
| sel2 | input | 1 | Secondary chip select, active high |
| sel3_n | input | 1 | Secondary chip select, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| lane_wr_n | input | 1 | Per-lane write enable, active low |
| lane_sel_n | input | LANES | Per-lane select, active low |
| burst_interleave | input | 1 | High: interleaved order, low: linear order |
| single_deselect | input | 1 | High: single-stage deselect, low: two-stage |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep_req | input | 1 | Sleep request, active high |
| wr_data | input | LANES*LANE_W | Write data |
| rd_data | output | LANES*LANE_W | Registered read data |
| rd_drive | output | 1 | Drive enable for the data pads |

## Verification
The bench builds the block with ADDR_W = 6 and REC_CYC = 3, against defaults of 8 and 16. A 64-word array leaves room for separate address regions for lane tests, burst tests and sleep tests, and bursts can wrap inside one aligned group without touching other words. A 3-cycle recovery window lets one short run show a blocked write at the first recovery edge and an accepted write at the first edge after the window. Burst order and deselect mode are pins, so both settings are tested on the same build.

// File: rtl/sbf_pkg.sv
// Shared types for the burst SRAM front-end.
// Assumes: every clock cycle decodes to exactly one of these command kinds.
package sbf_pkg;

    typedef enum logic [1:0] {
        C_NOP = 2'd0,   // cycle ignored (sleep or blocked write)
        C_RD  = 2'd1,
        C_WR  = 2'd2,
        C_DES = 2'd3
    } cmd_t;

    // Low address bits for a burst: start value combined with the step count.
    function automatic logic [1:0] burst_low(input logic [1:0] base,
                                             input logic [1:0] cnt,
                                             input logic       interleave);
        return interleave ? (base ^ cnt) : (base + cnt);
    endfunction

endpackage

// File: rtl/sbf_decode.sv
// Cycle decoder: turns the raw control pins of one clock into a command,
// a burst action (start / step / hold) and a lane write mask.
// Assumes: pins are stable around the clock edge; purely combinational.
module sbf_decode
    import sbf_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             proc_strobe_n,
    input  logic             ctrl_strobe_n,
    input  logic             advance_n,
    input  logic             sel_n,
    input  logic             sel2,
    input  logic             sel3_n,
    input  logic             all_wr_n,
    input  logic             lane_wr_n,
    input  logic [LANES-1:0] lane_sel_n,
    output cmd_t             cmd,
    output logic             start,
    output logic             step,
    output logic [LANES-1:0] lane_mask
);

    logic [LANES-1:0] wr_mask;

    // Lane selection from the global and per-lane write pins.
    always_comb begin
        if (!all_wr_n)       wr_mask = '1;
        else if (!lane_wr_n) wr_mask = ~lane_sel_n;
        else                 wr_mask = '0;
    end

    // Command priority: processor strobe, then controller strobe, then burst.
    always_comb begin
        cmd       = C_RD;
        start     = 1'b0;
        step      = 1'b0;
        lane_mask = '0;
        if (!sel_n && !proc_strobe_n) begin
            start = 1'b1;
        end else if (!ctrl_strobe_n) begin
            if (sel_n || !sel2 || sel3_n) begin
                cmd = C_DES;
            end else begin
                start     = 1'b1;
                cmd       = (|wr_mask) ? C_WR : C_RD;
                lane_mask = wr_mask;
            end
        end else begin
            step      = !advance_n;
            cmd       = (|wr_mask) ? C_WR : C_RD;
            lane_mask = wr_mask;
        end
    end

endmodule

// File: rtl/sbf_burst.sv
// Burst address generator: holds the start address and a 2-bit step count
// and produces the address used by the current cycle.
// Assumes: accept is low for cycles that must leave the burst state alone.
module sbf_burst
    import sbf_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              start,
    input  logic              step,
    input  logic              accept,
    input  logic              interleave,
    output logic [ADDR_W-1:0] cur_addr
);

    logic [ADDR_W-1:2] hi_q;
    logic [1:0]        base_q;
    logic [1:0]        cnt_q;
    logic [1:0]        cnt_use;

    // Address of this cycle: external on a start, counter-derived otherwise.
    always_comb begin
        cnt_use  = step ? cnt_q + 2'd1 : cnt_q;
        cur_addr = start ? ext_addr : {hi_q, burst_low(base_q, cnt_use, interleave)};
    end

    // Capture the start address or advance the step count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (accept && start) begin
            hi_q   <= ext_addr[ADDR_W-1:2];
            base_q <= ext_addr[1:0];
            cnt_q  <= '0;
        end else if (accept && step) begin
            cnt_q  <= cnt_q + 2'd1;
        end
    end

    assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && start) |=> (cnt_q == 2'd0));

    assert_step_counts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && step && !start) |=> (cnt_q == $past(cnt_q) + 2'd1));

endmodule

// File: rtl/sbf_sleep.sv
// Sleep sequencer: delays the sleep pin by two edges and, after release,
// holds a write-block window of REC_CYC cycles.
// Assumes: sleep_req is already synchronous to clk.
module sbf_sleep #(
    parameter int REC_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    output logic asleep,
    output logic recovering
);

    localparam int REC_W = $clog2(REC_CYC + 1);

    logic             sl1_q, sl2_q;
    logic [REC_W-1:0] rec_q;

    // Two-stage delay of the sleep request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sl1_q <= 1'b0;
            sl2_q <= 1'b0;
        end else begin
            sl1_q <= sleep_req;
            sl2_q <= sl1_q;
        end
    end

    // Recovery counter: reloaded while asleep, counts down afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n)              rec_q <= '0;
        else if (sl2_q)          rec_q <= REC_W'(REC_CYC);
        else if (rec_q != '0)    rec_q <= rec_q - 1'b1;
    end

    assign asleep     = sl2_q;
    assign recovering = (rec_q != '0);

    assert_reload_window_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sl2_q |=> (rec_q == REC_W'(REC_CYC)));

endmodule

// File: rtl/sbf_array.sv
// Storage array with per-lane writes and a registered read port.
// Assumes: one command per cycle; the array itself is not reset.
module sbf_array
    import sbf_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  cmd_t                    cmd_q,
    input  logic [ADDR_W-1:0]       addr_q,
    input  logic [LANES*LANE_W-1:0] wdata_q,
    input  logic [LANES-1:0]        mask_q,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Lane-masked write of the registered command.
    always_ff @(posedge clk) begin
        if (cmd_q == C_WR) begin
            for (int l = 0; l < LANES; l++) begin
                if (mask_q[l]) mem[addr_q][l*LANE_W +: LANE_W] <= wdata_q[l*LANE_W +: LANE_W];
            end
        end
    end

    // Read register feeding the data outputs.
    always_ff @(posedge clk) begin
        if (!rst_n)             rdata <= '0;
        else if (cmd_q == C_RD) rdata <= mem[addr_q];
    end

endmodule

// File: rtl/sram_burst_front.sv
// Top of the burst SRAM front-end: decodes each cycle, registers the command
// stage, drives the array and the output-drive state machine.
// Assumes: mode pins are static during a burst; out_en_n may change anytime.
module sram_burst_front
    import sbf_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int LANES   = 4,
    parameter int LANE_W  = 9,
    parameter int REC_CYC = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    proc_strobe_n,
    input  logic                    ctrl_strobe_n,
    input  logic                    advance_n,
    input  logic                    sel_n,
    input  logic                    sel2,
    input  logic                    sel3_n,
    input  logic                    all_wr_n,
    input  logic                    lane_wr_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic                    burst_interleave,
    input  logic                    single_deselect,
    input  logic                    out_en_n,
    input  logic                    sleep_req,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    rd_drive
);

    localparam int DATA_W = LANES * LANE_W;

    cmd_t              dec_cmd, cmd_eff, cmd_q;
    logic              dec_start, dec_step, accept;
    logic [LANES-1:0]  dec_mask, mask_q;
    logic [ADDR_W-1:0] cur_addr, addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              asleep, recovering, drv_q;

    sbf_decode #(.LANES(LANES)) u_decode (
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .advance_n     (advance_n),
        .sel_n         (sel_n),
        .sel2          (sel2),
        .sel3_n        (sel3_n),
        .all_wr_n      (all_wr_n),
        .lane_wr_n     (lane_wr_n),
        .lane_sel_n    (lane_sel_n),
        .cmd           (dec_cmd),
        .start         (dec_start),
        .step          (dec_step),
        .lane_mask     (dec_mask)
    );

    sbf_sleep #(.REC_CYC(REC_CYC)) u_sleep (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .asleep     (asleep),
        .recovering (recovering)
    );

    // Gate the decoded command with sleep and recovery state.
    always_comb begin
        accept  = !asleep && !((dec_cmd == C_WR) && recovering);
        cmd_eff = accept ? dec_cmd : C_NOP;
    end

    sbf_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_addr   (addr),
        .start      (dec_start),
        .step       (dec_step),
        .accept     (accept),
        .interleave (burst_interleave),
        .cur_addr   (cur_addr)
    );

    // Command stage: captures command, address, write data and lane mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= C_NOP;
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else begin
            cmd_q   <= cmd_eff;
            addr_q  <= cur_addr;
            wdata_q <= wr_data;
            mask_q  <= dec_mask;
        end
    end

    sbf_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_q   (cmd_q),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .mask_q  (mask_q),
        .rdata   (rd_data)
    );

    // Output-drive state: early release on writes and single-stage deselects.
    always_ff @(posedge clk) begin
        if (!rst_n)                                                drv_q <= 1'b0;
        else if (asleep)                                           drv_q <= 1'b0;
        else if (cmd_eff == C_WR || (single_deselect && cmd_eff == C_DES)) drv_q <= 1'b0;
        else if (cmd_q == C_RD)                                    drv_q <= 1'b1;
        else if (cmd_q != C_NOP)                                   drv_q <= 1'b0;
    end

    assign rd_drive = drv_q && !out_en_n && !asleep;

    assert_proc_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !sel_n && !proc_strobe_n) |=> (cmd_q != C_WR));

    assert_write_has_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == C_WR) |-> (mask_q != '0));

    assert_write_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == C_WR) |=> !drv_q);

    assert_single_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (single_deselect && cmd_eff == C_DES) |=> !drv_q);

    assert_oe_masks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !rd_drive);

    assert_sleep_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> (!rd_drive && cmd_eff == C_NOP));

endmodule

// File: tb/tb_sram_burst_front.sv
// Self-checking bench: a table of lane-write vectors, then directed tests.
module tb_sram_burst_front;

    localparam int AW = 6;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          proc_strobe_n, ctrl_strobe_n, advance_n;
    logic          sel_n, sel2, sel3_n;
    logic          all_wr_n, lane_wr_n;
    logic [3:0]    lane_sel_n;
    logic          burst_interleave, single_deselect, out_en_n, sleep_req;
    logic [DW-1:0] wr_data, rd_data;
    logic          rd_drive;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    sram_burst_front #(.ADDR_W(AW), .LANES(4), .LANE_W(9), .REC_CYC(3)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
        .advance_n(advance_n), .sel_n(sel_n), .sel2(sel2), .sel3_n(sel3_n),
        .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
        .burst_interleave(burst_interleave), .single_deselect(single_deselect),
        .out_en_n(out_en_n), .sleep_req(sleep_req),
        .wr_data(wr_data), .rd_data(rd_data), .rd_drive(rd_drive)
    );

    // Entry: {addr[5:0], all_wr_n, lane_wr_n, lane_sel_n[3:0]}
    localparam logic [11:0] VEC [8] = '{
        {6'd40, 1'b0, 1'b1, 4'hF},
        {6'd41, 1'b1, 1'b0, 4'hE},
        {6'd42, 1'b1, 1'b0, 4'h7},
        {6'd43, 1'b1, 1'b0, 4'hF},
        {6'd44, 1'b1, 1'b1, 4'h0},
        {6'd45, 1'b1, 1'b0, 4'h5},
        {6'd46, 1'b0, 1'b0, 4'hA},
        {6'd47, 1'b1, 1'b0, 4'h0}
    };

    function automatic logic [DW-1:0] pat(input logic [5:0] a, input logic [2:0] tag);
        return {4{tag, a}};
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1; advance_n = 1'b1;
        sel_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
        all_wr_n = 1'b1; lane_wr_n = 1'b1; lane_sel_n = 4'hF;
    endtask

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic g, input logic b, input logic [3:0] s);
        idle();
        addr = a; ctrl_strobe_n = 1'b0; wr_data = d;
        all_wr_n = g; lane_wr_n = b; lane_sel_n = s;
        step();
        idle();
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_ctl(a, d, 1'b0, 1'b1, 4'hF);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] q);
        idle();
        addr = a; ctrl_strobe_n = 1'b0;
        step();
        idle();
        step();
        q = rd_data;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] q;
        logic [DW-1:0] exp;
        rst_n = 1'b0;
        idle();
        addr = '0; wr_data = '0;
        burst_interleave = 1'b0; single_deselect = 1'b1;
        out_en_n = 1'b0; sleep_req = 1'b0;
        step(); step();
        chk("reset R8 drive", {35'd0, rd_drive}, '0);
        chk("reset R8 data", rd_data, '0);
        rst_n = 1'b1;
        step();

        // R7: lane-write table
        for (int i = 0; i < 8; i++) begin
            logic [5:0] a;
            logic [3:0] m;
            a = VEC[i][11:6];
            wr(a, pat(a, 3'd1));
            wr_ctl(a, pat(a, 3'd6), VEC[i][5], VEC[i][4], VEC[i][3:0]);
            if (!VEC[i][5])      m = 4'hF;
            else if (!VEC[i][4]) m = ~VEC[i][3:0];
            else                 m = 4'h0;
            for (int l = 0; l < 4; l++)
                exp[l*9 +: 9] = m[l] ? pat(a, 3'd6) >> (l*9) : pat(a, 3'd1) >> (l*9);
            rd(a, q);
            chk($sformatf("R7 lanes vector %0d", i), q, exp);
        end

        // R8: read latency and drive on
        wr(6'd5, pat(6'd5, 3'd2));
        idle(); addr = 6'd5; ctrl_strobe_n = 1'b0;
        step(); idle();
        step();
        chk("R8 read data", rd_data, pat(6'd5, 3'd2));
        chk("R8 drive on read", {35'd0, rd_drive}, 36'd1);

        // R10: asynchronous masking
        out_en_n = 1'b1; #1;
        chk("R10 oe high masks", {35'd0, rd_drive}, '0);
        out_en_n = 1'b0; #1;
        chk("R10 oe low restores", {35'd0, rd_drive}, 36'd1);

        // R8: write releases drive on its own edge
        wr(6'd6, pat(6'd6, 3'd2));
        chk("R8 write releases", {35'd0, rd_drive}, '0);

        // R3: processor strobe reads, ignores write pins
        idle(); addr = 6'd5; proc_strobe_n = 1'b0; all_wr_n = 1'b0; wr_data = '1;
        step(); idle();
        step();
        chk("R3 proc read data", rd_data, pat(6'd5, 3'd2));
        rd(6'd5, q);
        chk("R3 no write", q, pat(6'd5, 3'd2));

        // R4 / R9: primary select high with controller strobe -> deselect, no write
        idle(); addr = 6'd5; proc_strobe_n = 1'b0; step(); idle(); step();
        sel_n = 1'b1; ctrl_strobe_n = 1'b0; all_wr_n = 1'b0; wr_data = '0;
        step(); idle();
        chk("R9 single release", {35'd0, rd_drive}, '0);
        out_en_n = 1'b0; #1;
        chk("R10 oe cannot enable", {35'd0, rd_drive}, '0);
        rd(6'd5, q);
        chk("R4 deselect no write", q, pat(6'd5, 3'd2));

        // R5: secondary selects gate only controller cycles
        idle(); addr = 6'd5; ctrl_strobe_n = 1'b0; sel2 = 1'b0; all_wr_n = 1'b0; wr_data = '0;
        step(); idle(); step();
        rd(6'd5, q);
        chk("R5 ctrl sel2 low no write", q, pat(6'd5, 3'd2));
        idle(); addr = 6'd6; proc_strobe_n = 1'b0; sel3_n = 1'b1;
        step(); idle(); step();
        chk("R5 proc ignores sel3", rd_data, pat(6'd6, 3'd2));

        // R9: two-stage deselect
        single_deselect = 1'b0;
        idle(); addr = 6'd5; ctrl_strobe_n = 1'b0; step();
        idle(); sel_n = 1'b1; ctrl_strobe_n = 1'b0; step();
        idle();
        chk("R9 dual still on", {35'd0, rd_drive}, 36'd1);
        chk("R9 dual data", rd_data, pat(6'd5, 3'd2));
        step();
        chk("R9 dual release", {35'd0, rd_drive}, '0);
        single_deselect = 1'b1;

        // R1: linear burst from 10
        for (int a = 8; a < 12; a++) wr(6'(a), pat(6'(a), 3'd3));
        idle(); addr = 6'd10; ctrl_strobe_n = 1'b0; step();
        idle(); advance_n = 1'b0;
        for (int k = 0; k < 5; k++) begin
            logic [5:0] ea;
            ea = {4'd2, 2'(2 + k)};
            if (k == 4) advance_n = 1'b1;
            step();
            chk($sformatf("R1 linear step %0d", k), rd_data, pat(ea, 3'd3));
        end
        // R6: suspend repeats the current address (10 after wrap)
        step();
        chk("R6 suspend", rd_data, pat(6'd10, 3'd3));

        // R2: interleaved burst from 9
        burst_interleave = 1'b1;
        idle(); addr = 6'd9; ctrl_strobe_n = 1'b0; step();
        idle(); advance_n = 1'b0;
        for (int k = 0; k < 5; k++) begin
            logic [5:0] ea;
            ea = {4'd2, 2'd1 ^ 2'(k)};
            step();
            chk($sformatf("R2 interleave step %0d", k), rd_data, pat(ea, 3'd3));
        end
        burst_interleave = 1'b0;

        // R6: burst writes via continue and suspend
        idle(); addr = 6'd20; ctrl_strobe_n = 1'b0; all_wr_n = 1'b0; wr_data = pat(6'd20, 3'd4); step();
        idle(); advance_n = 1'b0; all_wr_n = 1'b0; wr_data = pat(6'd21, 3'd4); step();
        idle(); advance_n = 1'b1; all_wr_n = 1'b0; wr_data = pat(6'd21, 3'd5); step();
        idle();
        rd(6'd20, q);
        chk("R6 begin write", q, pat(6'd20, 3'd4));
        rd(6'd21, q);
        chk("R6 continue then suspend write", q, pat(6'd21, 3'd5));

        // R11 / R12: sleep and recovery
        wr(6'd30, pat(6'd30, 3'd1));
        wr(6'd31, pat(6'd31, 3'd1));
        wr(6'd32, pat(6'd32, 3'd1));
        rd(6'd30, q);
        sleep_req = 1'b1;
        step();
        chk("R11 edge k still active", {35'd0, rd_drive}, 36'd1);
        step();
        chk("R11 asleep drive off", {35'd0, rd_drive}, '0);
        wr(6'd30, pat(6'd30, 3'd7));
        step();
        chk("R11 asleep stays off", {35'd0, rd_drive}, '0);
        sleep_req = 1'b0;
        step(); step();
        wr(6'd31, pat(6'd31, 3'd7));
        step(); step();
        wr(6'd32, pat(6'd32, 3'd7));
        rd(6'd30, q);
        chk("R11 contents kept", q, pat(6'd30, 3'd1));
        rd(6'd31, q);
        chk("R12 write blocked", q, pat(6'd31, 3'd1));
        rd(6'd32, q);
        chk("R12 write after window", q, pat(6'd32, 3'd7));

        finish_run();
    end

endmodule